// File: doc/BRIEF.md
# Word-swapping DMA engine

This block moves 16-bit words between a byte-addressed, big-endian main memory and one of two word-addressed local memories of a coprocessor: a data memory, which can be read or written, and an instruction memory, which can only be loaded. Software sets up a transfer through six 16-bit registers. These are the two halves of the main byte address, the local word address, a control word and a byte length. A sixth register can suppress transfers. Writing the length register is what starts a transfer.

Once started, the engine keeps a short pipeline full. In each cycle it issues one synchronous read and writes back the word read in the previous cycle, so the transfer runs at one word per cycle. The two bytes of every word are exchanged on the way, in both directions. The engine applies a different address mask to main memory depending on the target. It reports completion with a one-cycle pulse and rejects requests that are too long or that are not supported.

Top module: `wswap_dma`

## Requirements
- R1: Register selects are 0 main-address high, 1 main-address low, 2 local word address, 3 control, 4 length, 5 suppress mask. Other selects read as zero, and writes to them are ignored. All registers read zero after reset. Word n of a transfer uses main byte address {high,low}+2n and local word address local+n, with the local address wrapping at 16 bits.
- R2: Control bit 1 selects the instruction memory (1) or the data memory (0). Control bit 0 set means local-to-main, clear means main-to-local. Bit 2 reads 1 exactly while a transfer runs, and software cannot write it. The other bits read back as written, and transfers never change them.
- R3: An idle write to the length register starts a transfer when it is accepted. While the transfer runs, the length register reads back the written value. When idle, it reads zero.
- R4: Every word has its two bytes exchanged. Main-to-local writes byte-swapped main data into local memory, and local-to-main writes byte-swapped data-memory words into main memory.
- R5: Main addresses are ANDed with 0x7FFFFFFF for data-memory transfers and with 0x0FFFFFFF for instruction-memory loads. The mask is applied to each word's address after the offset is added.
- R6: If the suppress mask register is nonzero when the length is written, no transfer happens and no error is raised.
- R7: A length above 0x4000 bytes raises the error flag and moves no data. A length of exactly 0x4000 is carried out as a full transfer.
- R8: Control bits 1:0 equal to 2'b11 (instruction memory to main) raise the error flag and move no data.
- R9: The word count is the length divided by two, rounded down, so a trailing odd byte is dropped. Lengths 0 and 1 move nothing and produce no done pulse.
- R10: For n words, done_o is high for exactly one cycle, starting at the (n+1)th rising edge after the edge that captured the length write. At that point busy has just dropped.
- R11: A length write made while a transfer runs is ignored. The running transfer is not changed, and no new transfer follows.
- R12: err_o is updated by every idle length write. It is set to 1 if that write was rejected under R7 or R8 (and not suppressed), and cleared to 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 16 | Register write data |
| rd_sel_i | input | 3 | Register select for the readback |
| rd_data_o | output | 16 | Readback data (combinational) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last idle length write was rejected |
| main_addr_o | output | 32 | Main memory byte address |
| main_re_o | output | 1 | Main memory read request (data the next cycle) |
| main_we_o | output | 1 | Main memory write |
| main_wdata_o | output | 16 | Main memory write data |
| main_rdata_i | input | 16 | Main memory read data |
| dmem_addr_o | output | LADDR_W | Data memory word address |
| dmem_re_o | output | 1 | Data memory read request (data the next cycle) |
| dmem_we_o | output | 1 | Data memory write |
| dmem_wdata_o | output | 16 | Data memory write data |
| dmem_rdata_i | input | 16 | Data memory read data |
| imem_addr_o | output | LADDR_W | Instruction memory word address |
| imem_we_o | output | 1 | Instruction memory write |
| imem_wdata_o | output | 16 | Instruction memory write data |

## Verification
The assertions take for granted that both memories return read data exactly one cycle after the request and that software writes at most one register per cycle. The bench models the memories as one-cycle registered functions of the address, so this latency always holds. It drives one register write at a time and changes the address, control and suppress registers only between transfers, except in the one case that deliberately writes the length register while the engine is busy.

// File: rtl/wswap_pkg.sv
package wswap_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    SEL_MAIN_HI = 3'd0,
    SEL_MAIN_LO = 3'd1,
    SEL_LOC     = 3'd2,
    SEL_CTRL    = 3'd3,
    SEL_LEN     = 3'd4,
    SEL_MASK    = 3'd5
  } reg_sel_e;

  localparam int CTL_TO_MAIN = 0;
  localparam int CTL_IMEM    = 1;
  localparam int CTL_BUSY    = 2;

  function automatic logic [WORD_W-1:0] swap16(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/wswap_regs.sv
module wswap_regs
  import wswap_pkg::*;
#(
  parameter int LADDR_W = 16,
  parameter int LEN_MAX = 16384,
  parameter int CNT_W   = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic [2:0]         rd_sel_i,
  output logic [WORD_W-1:0]  rd_data_o,
  input  logic               busy_i,
  output logic               start_o,
  output logic [CNT_W-1:0]   nwords_o,
  output logic [31:0]        main_base_o,
  output logic [LADDR_W-1:0] loc_base_o,
  output logic               to_main_o,
  output logic               to_imem_o,
  output logic               err_o
);
  logic [WORD_W-1:0] hi_q, lo_q, loc_q, ctrl_q, len_q, mask_q;
  logic              err_q;
  logic              len_hit, bad_req;

  assign len_hit  = wr_en_i && (wr_sel_i == SEL_LEN) && !busy_i;
  assign bad_req  = (int'(wr_data_i) > LEN_MAX) || (ctrl_q[1:0] == 2'b11);
  assign nwords_o = CNT_W'(wr_data_i >> 1);
  assign start_o  = len_hit && (mask_q == '0) && !bad_req && (nwords_o != '0);

  assign main_base_o = {hi_q, lo_q};
  assign loc_base_o  = LADDR_W'(loc_q);
  assign to_main_o   = ctrl_q[CTL_TO_MAIN];
  assign to_imem_o   = ctrl_q[CTL_IMEM];
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      loc_q  <= '0;
      ctrl_q <= '0;
      len_q  <= '0;
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en_i) begin
        case (wr_sel_i)
          SEL_MAIN_HI: hi_q   <= wr_data_i;
          SEL_MAIN_LO: lo_q   <= wr_data_i;
          SEL_LOC:     loc_q  <= wr_data_i;
          SEL_CTRL:    ctrl_q <= wr_data_i & ~(WORD_W'(1) << CTL_BUSY);
          SEL_MASK:    mask_q <= wr_data_i;
          default:     ;
        endcase
      end
      if (len_hit) err_q <= (mask_q == '0) && bad_req;
      if (start_o) len_q <= wr_data_i;
    end
  end

  always_comb begin
    case (rd_sel_i)
      SEL_MAIN_HI: rd_data_o = hi_q;
      SEL_MAIN_LO: rd_data_o = lo_q;
      SEL_LOC:     rd_data_o = loc_q;
      SEL_CTRL:    rd_data_o = ctrl_q | (busy_i ? (WORD_W'(1) << CTL_BUSY) : '0);
      SEL_LEN:     rd_data_o = busy_i ? len_q : '0;
      SEL_MASK:    rd_data_o = mask_q;
      default:     rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/wswap_mover.sv
module wswap_mover
  import wswap_pkg::*;
#(
  parameter int          LADDR_W    = 16,
  parameter int          CNT_W      = 14,
  parameter logic [31:0] DMEM_AMASK = 32'h7FFF_FFFF,
  parameter logic [31:0] IMEM_AMASK = 32'h0FFF_FFFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               to_main_i,
  input  logic               to_imem_i,
  input  logic [CNT_W-1:0]   nwords_i,
  input  logic [31:0]        main_base_i,
  input  logic [LADDR_W-1:0] loc_base_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [31:0]        main_addr_o,
  output logic               main_re_o,
  output logic               main_we_o,
  output logic [WORD_W-1:0]  main_wdata_o,
  input  logic [WORD_W-1:0]  main_rdata_i,
  output logic [LADDR_W-1:0] dmem_addr_o,
  output logic               dmem_re_o,
  output logic               dmem_we_o,
  output logic [WORD_W-1:0]  dmem_wdata_o,
  input  logic [WORD_W-1:0]  dmem_rdata_i,
  output logic [LADDR_W-1:0] imem_addr_o,
  output logic               imem_we_o,
  output logic [WORD_W-1:0]  imem_wdata_o
);
  logic [CNT_W-1:0]   left_q;
  logic [31:0]        rd_main_q, wr_main_q;
  logic [LADDR_W-1:0] rd_loc_q, wr_loc_q;
  logic               wr_vld_q, to_main_q, imem_q, done_q;
  logic               issue;
  logic [31:0]        amask;

  assign issue = (left_q != '0);
  assign amask = imem_q ? IMEM_AMASK : DMEM_AMASK;

  // read stage issues word k while write stage retires word k-1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q    <= '0;
      rd_main_q <= '0;
      wr_main_q <= '0;
      rd_loc_q  <= '0;
      wr_loc_q  <= '0;
      wr_vld_q  <= 1'b0;
      to_main_q <= 1'b0;
      imem_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= wr_vld_q && !issue;
      if (start_i) begin
        left_q    <= nwords_i;
        rd_main_q <= main_base_i;
        rd_loc_q  <= loc_base_i;
        to_main_q <= to_main_i;
        imem_q    <= to_imem_i;
        wr_vld_q  <= 1'b0;
      end else if (issue) begin
        left_q    <= left_q - CNT_W'(1);
        rd_main_q <= rd_main_q + 32'd2;
        rd_loc_q  <= rd_loc_q + LADDR_W'(1);
        wr_vld_q  <= 1'b1;
        wr_main_q <= rd_main_q;
        wr_loc_q  <= rd_loc_q;
      end else begin
        wr_vld_q  <= 1'b0;
      end
    end
  end

  assign busy_o = issue || wr_vld_q;
  assign done_o = done_q;

  assign main_addr_o  = (to_main_q ? wr_main_q : rd_main_q) & amask;
  assign main_re_o    = issue && !to_main_q;
  assign main_we_o    = wr_vld_q && to_main_q;
  assign main_wdata_o = swap16(dmem_rdata_i);

  assign dmem_addr_o  = to_main_q ? rd_loc_q : wr_loc_q;
  assign dmem_re_o    = issue && to_main_q;
  assign dmem_we_o    = wr_vld_q && !to_main_q && !imem_q;
  assign dmem_wdata_o = swap16(main_rdata_i);

  assign imem_addr_o  = wr_loc_q;
  assign imem_we_o    = wr_vld_q && !to_main_q && imem_q;
  assign imem_wdata_o = swap16(main_rdata_i);
endmodule

// File: rtl/wswap_dma.sv
module wswap_dma
  import wswap_pkg::*;
#(
  parameter int          LADDR_W    = 16,
  parameter int          LEN_MAX    = 16384,
  parameter logic [31:0] DMEM_AMASK = 32'h7FFF_FFFF,
  parameter logic [31:0] IMEM_AMASK = 32'h0FFF_FFFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [15:0]        wr_data_i,
  input  logic [2:0]         rd_sel_i,
  output logic [15:0]        rd_data_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [31:0]        main_addr_o,
  output logic               main_re_o,
  output logic               main_we_o,
  output logic [15:0]        main_wdata_o,
  input  logic [15:0]        main_rdata_i,
  output logic [LADDR_W-1:0] dmem_addr_o,
  output logic               dmem_re_o,
  output logic               dmem_we_o,
  output logic [15:0]        dmem_wdata_o,
  input  logic [15:0]        dmem_rdata_i,
  output logic [LADDR_W-1:0] imem_addr_o,
  output logic               imem_we_o,
  output logic [15:0]        imem_wdata_o
);
  localparam int MAX_WORDS = LEN_MAX / 2;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);

  logic               start;
  logic [CNT_W-1:0]   nwords;
  logic [31:0]        main_base;
  logic [LADDR_W-1:0] loc_base;
  logic               to_main, to_imem;

  wswap_regs #(
    .LADDR_W(LADDR_W), .LEN_MAX(LEN_MAX), .CNT_W(CNT_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .rd_sel_i    (rd_sel_i),
    .rd_data_o   (rd_data_o),
    .busy_i      (busy_o),
    .start_o     (start),
    .nwords_o    (nwords),
    .main_base_o (main_base),
    .loc_base_o  (loc_base),
    .to_main_o   (to_main),
    .to_imem_o   (to_imem),
    .err_o       (err_o)
  );

  wswap_mover #(
    .LADDR_W(LADDR_W), .CNT_W(CNT_W),
    .DMEM_AMASK(DMEM_AMASK), .IMEM_AMASK(IMEM_AMASK)
  ) u_mover (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .to_main_i    (to_main),
    .to_imem_i    (to_imem),
    .nwords_i     (nwords),
    .main_base_i  (main_base),
    .loc_base_i   (loc_base),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .main_addr_o  (main_addr_o),
    .main_re_o    (main_re_o),
    .main_we_o    (main_we_o),
    .main_wdata_o (main_wdata_o),
    .main_rdata_i (main_rdata_i),
    .dmem_addr_o  (dmem_addr_o),
    .dmem_re_o    (dmem_re_o),
    .dmem_we_o    (dmem_we_o),
    .dmem_wdata_o (dmem_wdata_o),
    .dmem_rdata_i (dmem_rdata_i),
    .imem_addr_o  (imem_addr_o),
    .imem_we_o    (imem_we_o),
    .imem_wdata_o (imem_wdata_o)
  );
endmodule

// File: rtl/wswap_dma_chk.sv
module wswap_dma_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic done_i,
  input logic err_i,
  input logic main_re_i,
  input logic main_we_i,
  input logic main_msb_i,
  input logic dmem_re_i,
  input logic dmem_we_i,
  input logic imem_we_i
);
  // R10
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!busy_i && $past(busy_i)));

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R3
  access_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_re_i || main_we_i || dmem_re_i || dmem_we_i || imem_we_i) |-> busy_i);

  // R5
  main_addr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_re_i || main_we_i) |-> !main_msb_i);

  // R2
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({main_we_i, dmem_we_i, imem_we_i}));

  // R12
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> !busy_i);
endmodule

bind wswap_dma wswap_dma_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy_o),
  .done_i     (done_o),
  .err_i      (err_o),
  .main_re_i  (main_re_o),
  .main_we_i  (main_we_o),
  .main_msb_i (main_addr_o[31]),
  .dmem_re_i  (dmem_re_o),
  .dmem_we_i  (dmem_we_o),
  .imem_we_i  (imem_we_o)
);

// File: tb/tb_wswap_dma.sv
module tb_wswap_dma;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  localparam logic [2:0] S_HI = 3'd0, S_LO = 3'd1, S_LOC = 3'd2,
                         S_CTRL = 3'd3, S_LEN = 3'd4, S_MASK = 3'd5;
  localparam logic [1:0] K_DMEM = 2'd0, K_IMEM = 2'd1, K_MAIN = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [15:0] data;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        busy, done, err;
  logic [31:0] main_addr;
  logic        main_re, main_we;
  logic [15:0] main_wdata;
  logic [15:0] main_rdata = '0;
  logic [15:0] dmem_addr;
  logic        dmem_re, dmem_we;
  logic [15:0] dmem_wdata;
  logic [15:0] dmem_rdata = '0;
  logic [15:0] imem_addr;
  logic        imem_we;
  logic [15:0] imem_wdata;

  int    n_chk = 0, n_fail = 0;
  int    cyc = 0, done_cnt = 0, done_at = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";
  logic [15:0] mask_val = '0;
  item_t wq[$];
  logic [31:0] rq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wswap_dma dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .busy_o(busy), .done_o(done), .err_o(err),
    .main_addr_o(main_addr), .main_re_o(main_re), .main_we_o(main_we),
    .main_wdata_o(main_wdata), .main_rdata_i(main_rdata),
    .dmem_addr_o(dmem_addr), .dmem_re_o(dmem_re), .dmem_we_o(dmem_we),
    .dmem_wdata_o(dmem_wdata), .dmem_rdata_i(dmem_rdata),
    .imem_addr_o(imem_addr), .imem_we_o(imem_we), .imem_wdata_o(imem_wdata)
  );

  function automatic logic [15:0] mword(input logic [7:0] i);
    return {i ^ 8'h5A, i + 8'h11};
  endfunction
  function automatic logic [15:0] dword(input logic [7:0] i);
    return {i + 8'h80, ~i};
  endfunction
  function automatic logic [15:0] sw(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  // memories: one-cycle registered reads
  always @(posedge clk) begin
    if (main_re) main_rdata <= mword(main_addr[8:1]);
    if (dmem_re) dmem_rdata <= dword(dmem_addr[7:0]);
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [49:0] act, input logic [49:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic cmp_wr(input logic [1:0] k, input logic [31:0] a, input logic [15:0] d);
    item_t e;
    item_t got;
    got = '{k, a, d};
    if (wq.size() == 0) chk(1'b0, cur_req, 50'(got), 50'(0));
    else begin
      e = wq.pop_front();
      chk(got == e, cur_req, 50'(got), 50'(e));
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        done_cnt++;
        done_at = cyc;
      end
      if (main_re) begin
        if (rq.size() == 0) chk(1'b0, cur_req, 50'(main_addr), 50'(0));
        else begin
          logic [31:0] ea;
          ea = rq.pop_front();
          chk(main_addr == ea, cur_req, 50'(main_addr), 50'(ea));
        end
      end
      if (dmem_we) cmp_wr(K_DMEM, {16'h0, dmem_addr}, dmem_wdata);
      if (imem_we) cmp_wr(K_IMEM, {16'h0, imem_addr}, imem_wdata);
      if (main_we) cmp_wr(K_MAIN, main_addr, main_wdata);
    end
  end

  task automatic reg_wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] s, output logic [15:0] d);
    rd_sel = s;
    #1;
    d = rd_data;
  endtask

  // driver: queue expected items, program, trigger, wait
  task automatic run_xfer(input string tag, input logic [15:0] ctrl, input logic [15:0] hi,
                          input logic [15:0] lo, input logic [15:0] loc, input logic [15:0] len,
                          input bit probe);
    int n;
    int d0, t0;
    bit bad;
    logic [31:0] msk, a;
    logic [15:0] v;
    cur_req = tag;
    bad = (len > 16'h4000) || (ctrl[1:0] == 2'b11);
    n = (mask_val != 0 || bad) ? 0 : int'(len >> 1);
    msk = ctrl[1] ? 32'h0FFF_FFFF : 32'h7FFF_FFFF;
    for (int i = 0; i < n; i++) begin
      a = ({hi, lo} + 32'(2 * i)) & msk;
      if (ctrl[0]) wq.push_back('{K_MAIN, a, sw(dword(8'(loc + 16'(i))))});
      else begin
        rq.push_back(a);
        wq.push_back('{ctrl[1] ? K_IMEM : K_DMEM, {16'h0, 16'(loc + 16'(i))}, sw(mword(a[8:1]))});
      end
    end
    reg_wr(S_HI, hi);
    reg_wr(S_LO, lo);
    reg_wr(S_LOC, loc);
    reg_wr(S_CTRL, ctrl);
    d0 = done_cnt;
    reg_wr(S_LEN, len);
    t0 = cyc;
    chk(err == (mask_val == 0 && bad), "R12", 50'(err), 50'(mask_val == 0 && bad));
    if (probe) begin
      reg_rd(S_CTRL, v);
      chk(v[2] == 1'b1, "R2", 50'(v), 50'(ctrl | 16'h4));
      reg_rd(S_LEN, v);
      chk(v == len, "R3", 50'(v), 50'(len));
      reg_wr(S_LEN, 16'h0008); // R11: ignored while busy
      chk(err == 1'b0, "R11", 50'(err), 50'(0));
    end
    if (n > 0) begin
      while (done_cnt == d0) @(negedge clk);
      chk(done_at - t0 == n + 1, "R10", 50'(done_at - t0), 50'(n + 1));
      repeat (3) @(negedge clk);
      chk(done_cnt == d0 + 1, "R10", 50'(done_cnt - d0), 50'(1));
    end else begin
      repeat (8) @(negedge clk);
      chk(done_cnt == d0, tag, 50'(done_cnt - d0), 50'(0));
    end
    chk(wq.size() == 0 && rq.size() == 0, tag, 50'(wq.size() + rq.size()), 50'(0));
    reg_rd(S_LEN, v);
    chk(v == 16'h0, "R3", 50'(v), 50'(0));
    reg_rd(S_CTRL, v);
    chk(v == (ctrl & ~16'h4), "R2", 50'(v), 50'(ctrl & ~16'h4));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int s = 0; s < 8; s++) begin
      reg_rd(3'(s), v);
      chk(v == 16'h0, "R1", 50'(v), 50'(0));
    end
    chk({busy, done, err} == 3'b000, "R1", 50'({busy, done, err}), 50'(0));

    // R1 R4 R5: main to data memory
    run_xfer("R4", 16'h0000, 16'h0000, 16'h0010, 16'h0020, 16'd8, 1'b0);
    // R9 R5: data memory to main, odd length, bit 31 dropped
    run_xfer("R9", 16'h0001, 16'h8000, 16'h0040, 16'h0100, 16'd7, 1'b0);
    // R5: instruction load uses 28-bit mask
    run_xfer("R5", 16'h0002, 16'hF000, 16'h0020, 16'h0300, 16'd10, 1'b0);

    // R2: bit 2 not writable, other bits kept
    reg_wr(S_CTRL, 16'hA5F7);
    reg_rd(S_CTRL, v);
    chk(v == 16'hA5F3, "R2", 50'(v), 50'(16'hA5F3));
    // R8: instruction memory to main rejected
    run_xfer("R8", 16'hA5F3, 16'h0000, 16'h0000, 16'h0000, 16'd8, 1'b0);
    // R7: overlong rejected
    run_xfer("R7", 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h4002, 1'b0);
    // R12: a good transfer clears the error
    run_xfer("R12", 16'h0000, 16'h0000, 16'h0004, 16'h0010, 16'd4, 1'b0);
    chk(err == 1'b0, "R12", 50'(err), 50'(0));

    // R6: suppressed
    reg_wr(S_MASK, 16'h0001);
    mask_val = 16'h0001;
    reg_rd(S_MASK, v);
    chk(v == 16'h0001, "R1", 50'(v), 50'(1));
    run_xfer("R6", 16'h0000, 16'h0000, 16'h0000, 16'h0040, 16'd8, 1'b0);
    run_xfer("R6", 16'h0000, 16'h0000, 16'h0000, 16'h0040, 16'h4002, 1'b0);
    reg_wr(S_MASK, 16'h0000);
    mask_val = 16'h0000;

    // R9: lengths 1 and 0 move nothing
    run_xfer("R9", 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'd1, 1'b0);
    run_xfer("R9", 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'd0, 1'b0);

    // R1: unmapped select ignored
    reg_wr(3'd7, 16'hFFFF);
    reg_rd(3'd7, v);
    chk(v == 16'h0, "R1", 50'(v), 50'(0));

    // R11 R3 R2: probes during a long transfer
    run_xfer("R11", 16'h0000, 16'h0000, 16'h0080, 16'h0200, 16'd32, 1'b1);

    // R7 R5 R1: largest length, address wrap through the mask
    run_xfer("R7", 16'h0000, 16'h7FFF, 16'hFFF0, 16'hFF00, 16'h4000, 1'b0);

    finish_run();
  end
endmodule